// File: doc/BRIEF.md
# CSR Access Check and Execute Unit

This block carries out one decoded control-and-status-register instruction per cycle against a small local bank of registers. Each request supplies a 12-bit register address, a 3-bit operation, a source operand, the hart's current privilege level and one flag from the program-counter capability. The flag says whether that capability grants access to system registers. The block decides whether the access is allowed. If it is, the block performs the read-modify-write and returns the previous register contents as a plain integer result, with the capability tag of the result cleared.

Two trap outputs report a refused access: one for an illegal instruction and one for a capability-permission fault. The illegal-instruction check wins when both would apply. The bank holds three floating-point control registers, a window of performance counters, and a window of machine scratch registers. The counter window has a low half and, for 32-bit data only, a high half. The counters are plain storage here; advancing them belongs to other logic. Instruction decode and trap-vector handling belong to the surrounding pipeline.

Top module: `csrx_unit`

## Requirements
- R1: The level an address needs is its bits [9:8]. A request whose `cur_priv` (00 user, 11 machine) is numerically below that level gets `trap_illegal`.
- R2: Any address with bits [9:8] = 01 gets `trap_illegal`, whatever the privilege or permission.
- R3: An address outside the bank gets `trap_illegal`, as does an operation code of 5, 6 or 7. The bank is 0x001–0x003, 0xB00–0xB03, 0xB80–0xB83 and 0x340–0x343 at the defaults.
- R4: The floating-point registers at 0x001–0x003 never raise `trap_cap`, whether `pcc_sys_perm` is set or clear.
- R5: A read-without-write (op 4) of a counter at 0xB00–0xB03 or 0xB80–0xB83 needs no `pcc_sys_perm`. Any other operation on a counter does need it.
- R6: An access that passes R1–R3, needs a level above user and is not exempt under R4/R5 raises `trap_cap` when `pcc_sys_perm` is 0. `trap_illegal` and `trap_cap` are never set together.
- R7: Op 0 writes the operand, op 1 ORs the operand in, and op 2 clears the operand's set bits. Each of these returns the old value with `rsp_wen` = 1.
- R8: Op 3 writes the operand and gives `rsp_wen` = 0 with `rsp_data` = 0. Op 4 returns the value with `rsp_wen` = 1, leaves the register unchanged, and is checked as a read.
- R9: `rsp_tag` is 0 on every response.
- R10: A trapped request changes no register and gives `rsp_wen` = 0 with `rsp_data` = 0.
- R11: Each response appears, with `rsp_valid` high for one cycle, in the cycle after its request. The register update made at that edge is seen by a request in the next cycle. Without a request, `rsp_valid`, `rsp_wen` and both traps are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | Register address |
| req_op | input | 3 | 0 swap, 1 set bits, 2 clear bits, 3 write only, 4 read only |
| req_operand | input | XLEN | Source operand |
| cur_priv | input | 2 | Current privilege level |
| pcc_sys_perm | input | 1 | Program-counter capability grants system-register access |
| rsp_valid | output | 1 | Response pulse, one cycle after the request |
| rsp_wen | output | 1 | Destination register is written |
| rsp_data | output | XLEN | Old register value for the destination |
| rsp_tag | output | 1 | Capability tag of the result, always cleared |
| trap_illegal | output | 1 | Illegal-instruction trap |
| trap_cap | output | 1 | Capability permission-violation trap |

## Verification
Any register update shows up at the ports only when a later request reads that register. A wrong write, a wrong set/clear merge or an update that a trap should have blocked therefore stays hidden until the next access to the same address. The bench makes that window short by mixing read-only requests into the random stream and by reading back directly after each directed trap case. A wrong permission decision is seen one cycle after the request, on the trap outputs or on a response that should not have been written.

// File: rtl/csrx_pkg.sv
package csrx_pkg;

   typedef enum logic [2:0] {
      OP_SWAP  = 3'd0,
      OP_SET   = 3'd1,
      OP_CLR   = 3'd2,
      OP_WONLY = 3'd3,
      OP_RONLY = 3'd4
   } csr_op_e;

   localparam logic [1:0] LVL_USER = 2'b00;
   localparam logic [1:0] LVL_SUPV = 2'b01;

   function automatic logic op_known(input logic [2:0] op);
      return op <= 3'd4;
   endfunction

   function automatic logic op_updates(input logic [2:0] op);
      return op != OP_RONLY;
   endfunction

   function automatic logic op_returns(input logic [2:0] op);
      return op != OP_WONLY;
   endfunction

endpackage

// File: rtl/csrx_addr_decode.sv
module csrx_addr_decode #(
   parameter int XLEN        = 32,
   parameter int NUM_FP      = 3,
   parameter int FP_BASE     = 'h001,
   parameter int NUM_CNT     = 4,
   parameter int CNT_LO_BASE = 'hB00,
   parameter int CNT_HI_BASE = 'hB80,
   parameter int NUM_MREG    = 4,
   parameter int MREG_BASE   = 'h340,
   localparam int NUM_HI     = (XLEN == 32) ? NUM_CNT : 0,
   localparam int NREG       = NUM_FP + NUM_CNT + NUM_HI + NUM_MREG
) (
   input  logic [11:0]     addr,
   output logic [NREG-1:0] hit,
   output logic            implemented,
   output logic            is_fp,
   output logic            is_cnt
);

   localparam int CNT_OFS  = NUM_FP;
   localparam int HI_OFS   = CNT_OFS + NUM_CNT;
   localparam int MREG_OFS = HI_OFS + NUM_HI;

   for (genvar i = 0; i < NUM_FP; i++) begin : g_fp
      assign hit[i] = (addr == 12'(FP_BASE + i));
   end

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt_lo
      assign hit[CNT_OFS + i] = (addr == 12'(CNT_LO_BASE + i));
   end

   if (NUM_HI > 0) begin : g_cnt_hi
      for (genvar i = 0; i < NUM_HI; i++) begin : g_slot
         assign hit[HI_OFS + i] = (addr == 12'(CNT_HI_BASE + i));
      end
   end

   for (genvar i = 0; i < NUM_MREG; i++) begin : g_mreg
      assign hit[MREG_OFS + i] = (addr == 12'(MREG_BASE + i));
   end

   assign implemented = |hit;
   assign is_fp       = |hit[NUM_FP-1:0];
   assign is_cnt      = |hit[CNT_OFS +: (NUM_CNT + NUM_HI)];

endmodule

// File: rtl/csrx_access_check.sv
module csrx_access_check
   import csrx_pkg::*;
(
   input  logic [1:0] need_lvl,
   input  logic [2:0] op,
   input  logic [1:0] priv,
   input  logic       sys_perm,
   input  logic       implemented,
   input  logic       is_fp,
   input  logic       is_cnt,
   output logic       illegal,
   output logic       cap_fault
);

   logic exempt;

   always_comb begin
      illegal = (need_lvl == LVL_SUPV) || (priv < need_lvl) ||
                !implemented || !op_known(op);
      exempt  = (need_lvl == LVL_USER) || is_fp ||
                (is_cnt && !op_updates(op));
      cap_fault = !illegal && !exempt && !sys_perm;
   end

endmodule

// File: rtl/csrx_reg_bank.sv
module csrx_reg_bank #(
   parameter int XLEN = 32,
   parameter int NREG = 15
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [NREG-1:0] sel,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] rdata
);

   logic [XLEN-1:0] q [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               q[i] <= '0;
         else if (we && sel[i])    q[i] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NREG; i++) begin
         if (sel[i]) rdata = rdata | q[i];
      end
   end

endmodule

// File: rtl/csrx_unit.sv
module csrx_unit
   import csrx_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int NUM_FP      = 3,
   parameter int FP_BASE     = 'h001,
   parameter int NUM_CNT     = 4,
   parameter int CNT_LO_BASE = 'hB00,
   parameter int CNT_HI_BASE = 'hB80,
   parameter int NUM_MREG    = 4,
   parameter int MREG_BASE   = 'h340
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [11:0]     req_addr,
   input  logic [2:0]      req_op,
   input  logic [XLEN-1:0] req_operand,
   input  logic [1:0]      cur_priv,
   input  logic            pcc_sys_perm,
   output logic            rsp_valid,
   output logic            rsp_wen,
   output logic [XLEN-1:0] rsp_data,
   output logic            rsp_tag,
   output logic            trap_illegal,
   output logic            trap_cap
);

   localparam int NUM_HI = (XLEN == 32) ? NUM_CNT : 0;
   localparam int NREG   = NUM_FP + NUM_CNT + NUM_HI + NUM_MREG;

   if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
      $error("csrx_unit: XLEN must be 32 or 64");
   end
   if (NUM_FP < 1 || NUM_MREG < 1 || NUM_CNT < 1 || NUM_CNT > 32) begin : g_bad_count
      $error("csrx_unit: register window sizes out of range");
   end
   if (((MREG_BASE >> 8) & 3) == 1) begin : g_bad_mreg
      $error("csrx_unit: scratch window must not sit at supervisor level");
   end

   logic [NREG-1:0] hit;
   logic            implemented, is_fp, is_cnt;
   logic            illegal, cap_fault, allowed;
   logic [XLEN-1:0] old_val, new_val;

   csrx_addr_decode #(
      .XLEN(XLEN), .NUM_FP(NUM_FP), .FP_BASE(FP_BASE),
      .NUM_CNT(NUM_CNT), .CNT_LO_BASE(CNT_LO_BASE), .CNT_HI_BASE(CNT_HI_BASE),
      .NUM_MREG(NUM_MREG), .MREG_BASE(MREG_BASE)
   ) i_decode (
      .addr        (req_addr),
      .hit         (hit),
      .implemented (implemented),
      .is_fp       (is_fp),
      .is_cnt      (is_cnt)
   );

   csrx_access_check i_check (
      .need_lvl    (req_addr[9:8]),
      .op          (req_op),
      .priv        (cur_priv),
      .sys_perm    (pcc_sys_perm),
      .implemented (implemented),
      .is_fp       (is_fp),
      .is_cnt      (is_cnt),
      .illegal     (illegal),
      .cap_fault   (cap_fault)
   );

   assign allowed = req_valid && !illegal && !cap_fault;

   always_comb begin
      case (req_op)
         OP_SET:  new_val = old_val | req_operand;
         OP_CLR:  new_val = old_val & ~req_operand;
         default: new_val = req_operand;
      endcase
   end

   csrx_reg_bank #(.XLEN(XLEN), .NREG(NREG)) i_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (allowed && op_updates(req_op)),
      .sel   (hit),
      .wdata (new_val),
      .rdata (old_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_wen      <= 1'b0;
         rsp_data     <= '0;
         trap_illegal <= 1'b0;
         trap_cap     <= 1'b0;
      end else begin
         rsp_valid    <= req_valid;
         rsp_wen      <= allowed && op_returns(req_op);
         rsp_data     <= (allowed && op_returns(req_op)) ? old_val : '0;
         trap_illegal <= req_valid && illegal;
         trap_cap     <= req_valid && cap_fault;
      end
   end

   assign rsp_tag = 1'b0;

endmodule

// File: rtl/csrx_unit_chk.sv
module csrx_unit_chk #(
   parameter int XLEN    = 32,
   parameter int NUM_FP  = 3,
   parameter int FP_BASE = 'h001
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [11:0]     req_addr,
   input logic [2:0]      req_op,
   input logic [1:0]      cur_priv,
   input logic            rsp_valid,
   input logic            rsp_wen,
   input logic [XLEN-1:0] rsp_data,
   input logic            trap_illegal,
   input logic            trap_cap
);

   // R11
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R11
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_wen && !trap_illegal && !trap_cap));

   // R6
   trap_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(trap_illegal && trap_cap));

   // R10
   trap_blocks_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_illegal || trap_cap) |-> (!rsp_wen && rsp_data == '0));

   // R2
   supv_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[9:8] == 2'b01) |=> trap_illegal);

   // R1
   priv_too_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cur_priv < req_addr[9:8]) |=> trap_illegal);

   // R4
   fp_no_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr >= 12'(FP_BASE) && req_addr < 12'(FP_BASE + NUM_FP))
      |=> !trap_cap);

   // R8
   wonly_no_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd3) |=> !rsp_wen);

endmodule

bind csrx_unit csrx_unit_chk #(.XLEN(XLEN), .NUM_FP(NUM_FP), .FP_BASE(FP_BASE)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_addr     (req_addr),
   .req_op       (req_op),
   .cur_priv     (cur_priv),
   .rsp_valid    (rsp_valid),
   .rsp_wen      (rsp_wen),
   .rsp_data     (rsp_data),
   .trap_illegal (trap_illegal),
   .trap_cap     (trap_cap)
);

// File: tb/test_csrx_unit.sv
module test_csrx_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [11:0] req_addr = '0;
   logic [2:0]  req_op = '0;
   logic [31:0] req_operand = '0;
   logic [1:0]  cur_priv = '0;
   logic        pcc_sys_perm = 1'b0;
   logic        rsp_valid, rsp_wen, rsp_tag, trap_illegal, trap_cap;
   logic [31:0] rsp_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [31:0] model [15];

   always #5 clk = ~clk;

   csrx_unit i_csrx_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_op(req_op), .req_operand(req_operand), .cur_priv(cur_priv),
      .pcc_sys_perm(pcc_sys_perm), .rsp_valid(rsp_valid), .rsp_wen(rsp_wen),
      .rsp_data(rsp_data), .rsp_tag(rsp_tag), .trap_illegal(trap_illegal),
      .trap_cap(trap_cap)
   );

   function automatic int ref_idx(input logic [11:0] a);
      if (a >= 12'h001 && a <= 12'h003) return int'(a) - 1;
      if (a >= 12'hB00 && a <= 12'hB03) return 3 + int'(a - 12'hB00);
      if (a >= 12'hB80 && a <= 12'hB83) return 7 + int'(a - 12'hB80);
      if (a >= 12'h340 && a <= 12'h343) return 11 + int'(a - 12'h340);
      return -1;
   endfunction

   function automatic logic [11:0] pick_addr(input int k);
      case (k)
         0: return 12'h001;  1: return 12'h002;  2: return 12'h003;
         3: return 12'h000;  4: return 12'hB00;  5: return 12'hB03;
         6: return 12'hB80;  7: return 12'hB82;  8: return 12'hB04;
         9: return 12'h340; 10: return 12'h341; 11: return 12'h342;
         12: return 12'h343; 13: return 12'h344; 14: return 12'h140;
         15: return 12'h240; 16: return 12'hC00; 17: return 12'h105;
         18: return 12'hB01; 19: return 12'h340;
         default: return 12'h341;
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_req(input logic [11:0] a, input logic [2:0] op,
                         input logic [31:0] v, input logic [1:0] pr, input logic pm);
      int idx;
      logic [1:0] lvl;
      logic ill, cap, ok, upd, ret;
      logic [31:0] old, nv;
      string tag;
      idx = ref_idx(a);
      lvl = a[9:8];
      ill = (lvl == 2'b01) || (pr < lvl) || (idx < 0) || (op > 3'd4);
      cap = !ill && (lvl != 2'b00) && !(idx >= 0 && idx < 3) &&
            !(idx >= 3 && idx < 11 && op == 3'd4) && !pm;
      ok  = !ill && !cap;
      upd = ok && (op != 3'd4);
      ret = ok && (op != 3'd3);
      old = (idx >= 0) ? model[idx] : 32'h0;
      case (op)
         3'd1: nv = old | v;
         3'd2: nv = old & ~v;
         default: nv = v;
      endcase
      if (lvl == 2'b01) tag = "R2";
      else if (pr < lvl) tag = "R1";
      else if (ill) tag = "R3";
      else if (cap) tag = "R6";
      else if (idx >= 0 && idx < 3) tag = "R4";
      else if (idx >= 3 && idx < 11) tag = "R5";
      else if (op >= 3'd3) tag = "R8";
      else tag = "R7";
      req_valid = 1'b1; req_addr = a; req_op = op; req_operand = v;
      cur_priv = pr; pcc_sys_perm = pm;
      @(negedge clk);
      check("R11", "rsp_valid", 32'(rsp_valid), 32'd1);
      check(tag, "trap_illegal", 32'(trap_illegal), 32'(ill));
      check(tag, "trap_cap", 32'(trap_cap), 32'(cap));
      check(ok ? tag : "R10", "rsp_wen", 32'(rsp_wen), 32'(ret));
      check(ok ? tag : "R10", "rsp_data", rsp_data, ret ? old : 32'h0);
      check("R9", "rsp_tag", 32'(rsp_tag), 32'd0);
      if (upd) model[idx] = nv;
      req_valid = 1'b0;
   endtask

   task automatic idle();
      req_valid = 1'b0;
      @(negedge clk);
      check("R11", "idle rsp_valid", 32'(rsp_valid), 32'd0);
      check("R11", "idle traps", 32'({trap_illegal, trap_cap, rsp_wen}), 32'd0);
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 15; i++) model[i] = 32'h0;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // reset state
      check("R11", "reset rsp_valid", 32'(rsp_valid), 32'd0);
      check("R10", "reset rsp_wen/data", 32'(rsp_wen) | rsp_data, 32'd0);
      check("R6", "reset traps", 32'({trap_illegal, trap_cap}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R7 swap / set / clear on scratch register
      do_req(12'h340, 3'd0, 32'hA5A5_0F0F, 2'b11, 1'b1);
      do_req(12'h340, 3'd1, 32'h0000_F000, 2'b11, 1'b1);
      do_req(12'h340, 3'd2, 32'hA000_000F, 2'b11, 1'b1);
      do_req(12'h340, 3'd4, 32'hFFFF_FFFF, 2'b11, 1'b1);
      // R8 write-only then read-only twice
      do_req(12'h341, 3'd3, 32'h1234_5678, 2'b11, 1'b1);
      do_req(12'h341, 3'd4, 32'h0, 2'b11, 1'b1);
      do_req(12'h341, 3'd4, 32'h0, 2'b11, 1'b1);
      // R2 supervisor address, all permissions
      do_req(12'h140, 3'd0, 32'hDEAD_BEEF, 2'b11, 1'b1);
      // R1 user privilege on machine register, then read back unchanged
      do_req(12'h341, 3'd0, 32'hFFFF_0000, 2'b00, 1'b1);
      do_req(12'h341, 3'd4, 32'h0, 2'b11, 1'b1);
      // R6 missing permission; R10 no update
      do_req(12'h342, 3'd0, 32'h5555_5555, 2'b11, 1'b0);
      do_req(12'h342, 3'd4, 32'h0, 2'b11, 1'b1);
      // R6 illegal takes priority over missing permission
      do_req(12'h344, 3'd0, 32'h1, 2'b11, 1'b0);
      // R5 counter read without permission ok, write without it traps
      do_req(12'hB00, 3'd3, 32'h0000_0077, 2'b11, 1'b1);
      do_req(12'hB00, 3'd4, 32'h0, 2'b11, 1'b0);
      do_req(12'hB80, 3'd4, 32'h0, 2'b11, 1'b0);
      do_req(12'hB00, 3'd0, 32'h9, 2'b11, 1'b0);
      do_req(12'hB00, 3'd1, 32'h0, 2'b11, 1'b0);
      // R4 floating-point registers, user mode, no permission
      do_req(12'h001, 3'd0, 32'h0000_001F, 2'b00, 1'b0);
      do_req(12'h003, 3'd1, 32'h0000_00E0, 2'b00, 1'b0);
      do_req(12'h001, 3'd4, 32'h0, 2'b00, 1'b0);
      // R3 unknown op codes and unimplemented addresses
      do_req(12'h340, 3'd5, 32'h1, 2'b11, 1'b1);
      do_req(12'h340, 3'd7, 32'h1, 2'b11, 1'b1);
      do_req(12'hC00, 3'd4, 32'h0, 2'b00, 1'b1);
      do_req(12'h340, 3'd4, 32'h0, 2'b11, 1'b1);
      idle();
      // random mix
      for (int n = 0; n < 1200; n++) begin
         logic [2:0] op;
         logic [1:0] pr;
         op = ($urandom % 10 < 9) ? 3'($urandom % 5) : 3'(5 + $urandom % 3);
         pr = ($urandom % 8 < 6) ? (($urandom % 2) ? 2'b11 : 2'b00) : 2'($urandom % 4);
         do_req(pick_addr(int'($urandom % 20)), op, $urandom, pr, 1'($urandom % 4 != 0));
         if (n % 9 == 8) idle();
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule